// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block is the data cache of a processor core: 4 ways of 256 lines, each line 32 bytes, 32 KB in all. The core presents one load or store at a time. Each request carries two addresses. The virtual address picks the set and the physical address, already translated, supplies the tag that is compared against each way. A load returns one 32-bit word. A store carries a 32-bit word with per-byte enables.

On a miss the controller fetches the whole line as an 8-beat burst over a simple memory port. A configuration input selects the write policy at run time. In copy-back mode, stores stay in the cache and mark the line dirty. A dirty victim is written back as an 8-beat burst before the refill starts. In write-through mode, every store also goes to memory as a single-word write, and a store miss does not allocate a line. Within a set, the victim is the first invalid way. When all four ways are valid, the victim is the least recently used way, tracked by six pairwise-order flags per set.

Top module: `vipt_dcache`

## Requirements
- R1: A synchronous reset leaves `busy`, `respValid` and `memReq` low and marks every line invalid, so the first load after reset misses.
- R2: A load that hits raises `respValid` for exactly one cycle, two clock edges after the request is accepted, with the addressed word on `respRdata` and no memory traffic.
- R3: The set index is virtual address bits [12:5] and the tag is physical address bits [31:12]. A request that matches a stored tag but selects another set misses, and so does one that selects the same set with another tag. At most one way hits.
- R4: A miss that allocates issues one read burst of 8 beats (`memBurst`=1, `memWrite`=0). `memAddr` is held at the line base, physical address with bits [4:0] cleared, and beat k returns the word at base+4k. The response then carries the requested word.
- R5: In copy-back mode (`cfgCopyBack`=1) a store hit updates the line, marks it dirty and causes no memory traffic. A store miss allocates the line and then applies the store.
- R6: When the chosen victim is valid and dirty, an 8-beat write burst carries its 32 bytes to {stored tag, index bits [11:5], 5'b0} before the refill burst begins. A clean victim causes no write burst.
- R7: In write-through mode (`cfgCopyBack`=0) a store hit updates the line and issues one single-word memory write (`memBurst`=0). The write uses the word-aligned physical address and the request's byte enables.
- R8: In write-through mode a store miss issues one single-word memory write and allocates nothing, so a later load of that line misses.
- R9: The victim is the lowest-numbered invalid way if the set has one. Otherwise it is the least recently used way, where loads, stores and fills all count as uses.
- R10: `busy` is high from the cycle after acceptance until the response. Requests are taken only while `busy` is low, and `memReq` is never high while `busy` is low.
- R11: A store changes only the bytes whose enable bit is 1. Enable bit b covers data bits [8b+7:8b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgCopyBack | input | 1 | 1 selects copy-back, 0 selects write-through |
| reqValid | input | 1 | Request present; taken when `busy` is low |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqVaddr | input | 32 | Virtual address, used for set selection |
| reqPaddr | input | 32 | Physical address, used for tag and memory addresses |
| reqWdata | input | 32 | Store data |
| reqBe | input | 4 | Store byte enables |
| busy | output | 1 | Request in progress; no new request taken |
| respValid | output | 1 | One-cycle completion pulse |
| respRdata | output | 32 | Load data, valid with `respValid` |
| memReq | output | 1 | Memory transfer requested |
| memWrite | output | 1 | Transfer direction, 1 for write |
| memBurst | output | 1 | 1 for an 8-beat line burst, 0 for a single word |
| memAddr | output | 32 | Line base for bursts, word address for single writes |
| memWdata | output | 32 | Write data for the current beat |
| memBe | output | 4 | Byte enables, all ones in bursts |
| memReady | input | 1 | Current beat transfers at this clock edge |
| memRdata | input | 32 | Read data for the current beat |

## Verification
The checks assume that the physical and virtual addresses agree in bits [11:0], so that a written-back line lands at the physical address it was filled from. The stimulus always builds both addresses from the same page offset. The checks also assume that the memory side keeps `memReady` tied to an active `memReq`, and that the core raises `reqValid` only while `busy` is low. The bench drives one request at a time and waits for `respValid` before it issues the next. The design is not checked against aliasing in virtual bit 12. The bench provokes it only with loads, which compare the same tags.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
  localparam int WAYS       = 4;
  localparam int LINE_BYTES = 32;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = WORD_BYTES * 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int BEATS      = LINE_BYTES / WORD_BYTES;
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int LRU_W      = WAYS * (WAYS - 1) / 2;

  typedef enum logic [1:0] {MS_NONE, MS_WB, MS_FILL, MS_WT} memSel_t;

  typedef struct packed {
    logic              capture;
    logic              hitUpdate;
    logic              writeData;
    logic              setDirty;
    logic              loadResp;
    logic              fillBeat;
    logic              fillDone;
    memSel_t           memSel;
    logic [BEAT_W-1:0] beat;
  } dpStrobes_t;

  // flag index of way pair (i, j), i < j; flag 1 means way i is newer
  function automatic int pairIdx(int i, int j);
    return i * WAYS - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  function automatic logic [LRU_W-1:0] lruTouch(logic [LRU_W-1:0] cur, logic [WAYS-1:0] wayOh);
    logic [LRU_W-1:0] nxt;
    nxt = cur;
    for (int i = 0; i < WAYS; i++)
      for (int j = i + 1; j < WAYS; j++) begin
        if (wayOh[i])      nxt[pairIdx(i, j)] = 1'b1;
        else if (wayOh[j]) nxt[pairIdx(i, j)] = 1'b0;
      end
    return nxt;
  endfunction

  function automatic logic [WAYS-1:0] lruOldest(logic [LRU_W-1:0] cur);
    logic [WAYS-1:0] res;
    for (int w = 0; w < WAYS; w++) begin
      res[w] = 1'b1;
      for (int v = 0; v < WAYS; v++) begin
        if (v > w && cur[pairIdx(w, v)])  res[w] = 1'b0;
        if (v < w && !cur[pairIdx(v, w)]) res[w] = 1'b0;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/dcache_datapath.sv
`timescale 1ns/1ps
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int TAG_LO = 12
)(
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobes_t            strobe,
  input  logic [ADDR_W-1:0]     reqVaddr,
  input  logic [ADDR_W-1:0]     reqPaddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [WORD_BYTES-1:0] reqBe,
  input  logic [DATA_W-1:0]     memRdata,
  output logic                  hit,
  output logic                  victimDirty,
  output logic [DATA_W-1:0]     respRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic [WORD_BYTES-1:0] memBe
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int PIDX_W = TAG_LO - OFF_W;

  logic [LINE_W-1:0] dataArr [WAYS][SETS];
  logic [TAG_W-1:0]  tagArr  [WAYS][SETS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAYS-1:0]   dirtyArr [SETS];
  logic [LRU_W-1:0]  lruArr   [SETS];

  logic [IDX_W-1:0]      rIdx;
  logic [ADDR_W-1:0]     rPaddr;
  logic [DATA_W-1:0]     rWdata;
  logic [WORD_BYTES-1:0] rBe;

  logic [TAG_W-1:0]  rTag;
  logic [BEAT_W-1:0] wSel;
  logic [WAYS-1:0]   hitVec, victimOh, invalidVec;
  logic [LINE_W-1:0] hitLine, victimLine;
  logic [TAG_W-1:0]  victimTag;
  logic              found;
  logic              unusedBits;

  assign rTag = rPaddr[ADDR_W-1:TAG_LO];
  assign wSel = rPaddr[OFF_W-1:BYTE_W];
  assign unusedBits = ^{reqVaddr[ADDR_W-1:OFF_W+IDX_W], reqVaddr[OFF_W-1:0], rPaddr[BYTE_W-1:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validArr[rIdx][w] && (tagArr[w][rIdx] == rTag);
  end
  assign hit = |hitVec;

  always_comb begin
    hitLine    = '0;
    victimLine = '0;
    victimTag  = '0;
    victimOh   = '0;
    found      = 1'b0;
    invalidVec = ~validArr[rIdx];
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitLine = hitLine | dataArr[w][rIdx];
    if (|invalidVec) begin
      for (int w = 0; w < WAYS; w++)
        if (invalidVec[w] && !found) begin
          victimOh[w] = 1'b1;
          found       = 1'b1;
        end
    end else begin
      victimOh = lruOldest(lruArr[rIdx]);
    end
    for (int w = 0; w < WAYS; w++)
      if (victimOh[w]) begin
        victimLine = victimLine | dataArr[w][rIdx];
        victimTag  = victimTag | tagArr[w][rIdx];
      end
  end

  assign victimDirty = |(victimOh & validArr[rIdx] & dirtyArr[rIdx]);

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memBe    = '0;
    case (strobe.memSel)
      MS_WB: begin
        memAddr  = {victimTag, rIdx[PIDX_W-1:0], {OFF_W{1'b0}}};
        memWdata = victimLine[int'(strobe.beat)*DATA_W +: DATA_W];
        memBe    = '1;
      end
      MS_FILL: begin
        memAddr = {rPaddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        memBe   = '1;
      end
      MS_WT: begin
        memAddr  = {rPaddr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        memWdata = rWdata;
        memBe    = rBe;
      end
      default: ;
    endcase
  end

  // line storage and request capture, no reset
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      rIdx   <= reqVaddr[OFF_W+IDX_W-1:OFF_W];
      rPaddr <= reqPaddr;
      rWdata <= reqWdata;
      rBe    <= reqBe;
    end
    if (strobe.loadResp) respRdata <= hitLine[int'(wSel)*DATA_W +: DATA_W];
    for (int w = 0; w < WAYS; w++) begin
      if (strobe.writeData && hitVec[w])
        for (int b = 0; b < WORD_BYTES; b++)
          if (rBe[b]) dataArr[w][rIdx][(int'(wSel)*WORD_BYTES+b)*8 +: 8] <= rWdata[b*8 +: 8];
      if (strobe.fillBeat && victimOh[w])
        dataArr[w][rIdx][int'(strobe.beat)*DATA_W +: DATA_W] <= memRdata;
      if (strobe.fillDone && victimOh[w])
        tagArr[w][rIdx] <= rTag;
    end
  end

  // line state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        lruArr[s]   <= '0;
      end
    end else begin
      if (strobe.hitUpdate) lruArr[rIdx] <= lruTouch(lruArr[rIdx], hitVec);
      if (strobe.setDirty)  dirtyArr[rIdx] <= dirtyArr[rIdx] | hitVec;
      if (strobe.fillDone) begin
        validArr[rIdx] <= validArr[rIdx] | victimOh;
        dirtyArr[rIdx] <= dirtyArr[rIdx] & ~victimOh;
        lruArr[rIdx]   <= lruTouch(lruArr[rIdx], victimOh);
      end
    end
  end

  assert_one_hit_R3: assert property (@(posedge clk) disable iff (rst) $onehot0(hitVec));
  assert_fill_one_way_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.fillBeat |-> $onehot(victimOh));
endmodule

// File: rtl/dcache_ctrl.sv
`timescale 1ns/1ps
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       cfgCopyBack,
  input  logic       memReady,
  input  logic       hit,
  input  logic       victimDirty,
  output dpStrobes_t strobe,
  output logic       busy,
  output logic       respValid,
  output logic       memReq,
  output logic       memWrite,
  output logic       memBurst
);
  typedef enum logic [2:0] {ST_IDLE, ST_LOOKUP, ST_WRBACK, ST_REFILL, ST_WTWRITE} ctrlState_t;

  ctrlState_t        state, nxtState;
  logic [BEAT_W-1:0] beatCnt;
  logic              rWrite, done, lastBeat;

  assign lastBeat = (beatCnt == BEAT_W'(BEATS - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nxtState    = state;
    strobe      = '0;
    strobe.beat = beatCnt;
    memReq      = 1'b0;
    memWrite    = 1'b0;
    memBurst    = 1'b0;
    done        = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        nxtState       = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (hit) begin
          strobe.hitUpdate = 1'b1;
          strobe.writeData = rWrite;
          strobe.setDirty  = rWrite && cfgCopyBack;
          strobe.loadResp  = !rWrite;
          if (rWrite && !cfgCopyBack) nxtState = ST_WTWRITE;
          else begin
            nxtState = ST_IDLE;
            done     = 1'b1;
          end
        end else if (rWrite && !cfgCopyBack) nxtState = ST_WTWRITE;
        else if (victimDirty)                nxtState = ST_WRBACK;
        else                                 nxtState = ST_REFILL;
      end
      ST_WRBACK: begin
        memReq        = 1'b1;
        memWrite      = 1'b1;
        memBurst      = 1'b1;
        strobe.memSel = MS_WB;
        if (memReady && lastBeat) nxtState = ST_REFILL;
      end
      ST_REFILL: begin
        memReq        = 1'b1;
        memBurst      = 1'b1;
        strobe.memSel = MS_FILL;
        if (memReady) begin
          strobe.fillBeat = 1'b1;
          if (lastBeat) begin
            strobe.fillDone = 1'b1;
            nxtState        = ST_LOOKUP;
          end
        end
      end
      ST_WTWRITE: begin
        memReq        = 1'b1;
        memWrite      = 1'b1;
        strobe.memSel = MS_WT;
        if (memReady) begin
          done     = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      beatCnt   <= '0;
      rWrite    <= 1'b0;
      respValid <= 1'b0;
    end else begin
      state     <= nxtState;
      respValid <= done;
      if (strobe.capture) rWrite <= reqWrite;
      if (memReq && memBurst && memReady) beatCnt <= beatCnt + 1'b1;
    end
  end

  assert_no_mem_idle_R10: assert property (@(posedge clk) disable iff (rst) !busy |-> !memReq);
  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (rst) respValid |=> !respValid);
  assert_wb_dirty_only_R6: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWrite && memBurst) |-> victimDirty);
  assert_hold_req_R4: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |=> memReq);
endmodule

// File: rtl/vipt_dcache.sv
`timescale 1ns/1ps
module vipt_dcache
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int TAG_LO = 12
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgCopyBack,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqVaddr,
  input  logic [ADDR_W-1:0]     reqPaddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [WORD_BYTES-1:0] reqBe,
  output logic                  busy,
  output logic                  respValid,
  output logic [DATA_W-1:0]     respRdata,
  output logic                  memReq,
  output logic                  memWrite,
  output logic                  memBurst,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic [WORD_BYTES-1:0] memBe,
  input  logic                  memReady,
  input  logic [DATA_W-1:0]     memRdata
);
  dpStrobes_t strobe;
  logic       hit, victimDirty;

  dcache_ctrl u_ctrl (
    .clk, .rst, .reqValid, .reqWrite, .cfgCopyBack, .memReady,
    .hit, .victimDirty, .strobe, .busy, .respValid, .memReq, .memWrite, .memBurst
  );

  dcache_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .TAG_LO(TAG_LO)) u_dp (
    .clk, .rst, .strobe, .reqVaddr, .reqPaddr, .reqWdata, .reqBe, .memRdata,
    .hit, .victimDirty, .respRdata, .memAddr, .memWdata, .memBe
  );

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |=> $stable(memAddr));
endmodule

// File: tb/tb_vipt_dcache.sv
`timescale 1ns/1ps
module tb_vipt_dcache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgCopyBack = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0, reqPaddr = '0, reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        busy, respValid, memReq, memWrite, memBurst;
  logic [31:0] respRdata, memAddr, memWdata;
  logic [3:0]  memBe;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;

  always #2 clk = ~clk;

  vipt_dcache dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] memArr [logic [31:0]];
  logic [31:0] truthArr [logic [31:0]];

  function automatic logic [31:0] defWord(logic [31:0] a);
    return a ^ 32'hC3C3_5A5A;
  endfunction
  function automatic logic [31:0] memWord(logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : defWord(a);
  endfunction
  function automatic logic [31:0] truthWord(logic [31:0] a);
    return truthArr.exists(a) ? truthArr[a] : defWord(a);
  endfunction
  function automatic logic [31:0] mergeBe(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // memory model: ready whenever requested, beats logged on the following negedge
  int nBurstRd = 0, nBurstWr = 0, nSingleWr = 0, seq = 0, rdSeq = 0, wrSeq = 0, bBeat = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0, lastSgAddr = '0, lastSgData = '0;
  logic [3:0]  lastSgBe = '0;
  logic [31:0] wbWords [8];
  logic        pValid = 1'b0, pWrite = 1'b0, pBurst = 1'b0;
  logic [31:0] pAddr = '0, pWdata = '0;
  logic [3:0]  pBe = '0;

  always @(negedge clk) begin
    if (pValid) begin
      if (pBurst) begin
        if (pWrite) begin
          memArr[pAddr + 32'(bBeat*4)] = pWdata;
          wbWords[bBeat] = pWdata;
          if (bBeat == 0) begin nBurstWr++; lastWrAddr = pAddr; seq++; wrSeq = seq; end
        end else if (bBeat == 0) begin
          nBurstRd++; lastRdAddr = pAddr; seq++; rdSeq = seq;
        end
        bBeat = (bBeat + 1) % 8;
      end else begin
        memArr[pAddr] = mergeBe(memWord(pAddr), pWdata, pBe);
        nSingleWr++; lastSgAddr = pAddr; lastSgData = pWdata; lastSgBe = pBe;
      end
    end
    pValid   = (memReq === 1'b1);
    pWrite   = memWrite; pBurst = memBurst; pAddr = memAddr; pWdata = memWdata; pBe = memBe;
    memReady = (memReq === 1'b1);
    memRdata = memWord(memAddr + 32'(bBeat*4));
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  int lat;
  logic [31:0] rd;
  logic sawBusy;

  // one request from a negedge with busy low; returns 1ns after the response negedge
  task automatic doReq(input logic wr, input logic [31:0] va, input logic [31:0] pa,
                       input logic [31:0] wd, input logic [3:0] be);
    reqValid = 1'b1; reqWrite = wr; reqVaddr = va; reqPaddr = pa; reqWdata = wd; reqBe = be;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; sawBusy = busy;
    while (!respValid && lat < 200) begin
      @(negedge clk);
      lat++;
      if (busy) sawBusy = 1'b1;
    end
    rd = respRdata;
    if (wr) truthArr[{pa[31:2], 2'b00}] = mergeBe(truthWord({pa[31:2], 2'b00}), wd, be);
    #1;
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    check(respValid == 1'b0, "R1", "respValid after reset", 32'(respValid), 0);
    check(memReq == 1'b0, "R10", "memReq idle", 32'(memReq), 0);
  endtask

  task automatic testMissThenHit();
    int r0;
    r0 = nBurstRd;
    doReq(0, 32'h0000_1044, 32'h8000_1044, 0, 0);
    check(nBurstRd == r0 + 1, "R1", "first load refills", 32'(nBurstRd - r0), 1);
    check(lastRdAddr == 32'h8000_1040, "R4", "refill line address", lastRdAddr, 32'h8000_1040);
    check(rd == truthWord(32'h8000_1044), "R4", "miss data", rd, truthWord(32'h8000_1044));
    check(sawBusy && !busy, "R10", "busy during miss, low at response", 32'(sawBusy), 1);
    r0 = nBurstRd;
    doReq(0, 32'h0000_1044, 32'h8000_1044, 0, 0);
    check(lat == 2, "R2", "hit latency", 32'(lat), 2);
    check(rd == truthWord(32'h8000_1044), "R2", "hit data", rd, truthWord(32'h8000_1044));
    doReq(0, 32'h0000_105C, 32'h8000_105C, 0, 0);
    check(nBurstRd == r0 && rd == truthWord(32'h8000_105C), "R2", "other word same line", rd,
          truthWord(32'h8000_105C));
  endtask

  task automatic testIndexTag();
    int r0;
    r0 = nBurstRd;
    doReq(0, 32'h0000_1048, 32'h9000_1048, 0, 0);
    check(nBurstRd == r0 + 1 && lastRdAddr == 32'h9000_1040, "R3", "same set new tag misses",
          lastRdAddr, 32'h9000_1040);
    check(rd == truthWord(32'h9000_1048), "R3", "new tag data", rd, truthWord(32'h9000_1048));
    r0 = nBurstRd;
    doReq(0, 32'h0000_0048, 32'h9000_1048, 0, 0);
    check(nBurstRd == r0 + 1, "R3", "same tag other set misses", 32'(nBurstRd - r0), 1);
  endtask

  task automatic testCopyBackWrite();
    int r0, w0, s0;
    cfgCopyBack = 1'b1;
    r0 = nBurstRd; w0 = nBurstWr; s0 = nSingleWr;
    doReq(1, 32'h0000_1044, 32'h8000_1044, 32'hDEAD_BEEF, 4'b0101);
    check(nBurstRd == r0 && nBurstWr == w0 && nSingleWr == s0, "R5", "store hit silent",
          32'(nSingleWr - s0), 0);
    doReq(0, 32'h0000_1044, 32'h8000_1044, 0, 0);
    check(rd == truthWord(32'h8000_1044), "R11", "byte merge", rd, truthWord(32'h8000_1044));
  endtask

  task automatic testLruWriteBack();
    int r0, w0;
    cfgCopyBack = 1'b1;
    for (int t = 0; t < 4; t++) doReq(0, 32'h0000_0800, 32'hA000_0800 + 32'(t) * 32'h1_0000, 0, 0);
    doReq(1, 32'h0000_0804, 32'hA001_0804, 32'h1234_5678, 4'b1111);
    r0 = nBurstRd; w0 = nBurstWr;
    doReq(0, 32'h0000_0800, 32'hA000_0800, 0, 0);
    doReq(0, 32'h0000_0800, 32'hA002_0800, 0, 0);
    doReq(0, 32'h0000_0800, 32'hA003_0800, 0, 0);
    check(nBurstRd == r0 && nBurstWr == w0, "R9", "four ways resident", 32'(nBurstRd - r0), 0);
    doReq(0, 32'h0000_0800, 32'hA004_0800, 0, 0);
    check(nBurstWr == w0 + 1 && lastWrAddr == 32'hA001_0800, "R6", "dirty LRU victim written back",
          lastWrAddr, 32'hA001_0800);
    check(wbWords[1] == 32'h1234_5678, "R6", "write-back word", wbWords[1], 32'h1234_5678);
    check(wrSeq < rdSeq && lastRdAddr == 32'hA004_0800, "R6", "write-back before refill",
          lastRdAddr, 32'hA004_0800);
    r0 = nBurstRd; w0 = nBurstWr;
    doReq(0, 32'h0000_0804, 32'hA001_0804, 0, 0);
    check(nBurstRd == r0 + 1 && nBurstWr == w0, "R9", "clean LRU victim, no write burst",
          32'(nBurstWr - w0), 0);
    check(rd == 32'h1234_5678, "R6", "evicted data survives", rd, 32'h1234_5678);
    r0 = nBurstRd;
    doReq(0, 32'h0000_0800, 32'hA002_0800, 0, 0);
    check(nBurstRd == r0 && lat == 2, "R9", "newer way kept", 32'(nBurstRd - r0), 0);
    r0 = nBurstRd;
    doReq(1, 32'h0000_0A00, 32'hA005_0A00, 32'h5555_AAAA, 4'b0011);
    check(nBurstRd == r0 + 1, "R5", "copy-back store miss allocates", 32'(nBurstRd - r0), 1);
    doReq(0, 32'h0000_0A00, 32'hA005_0A00, 0, 0);
    check(rd == truthWord(32'hA005_0A00) && lat == 2, "R5", "allocated store visible", rd,
          truthWord(32'hA005_0A00));
  endtask

  task automatic testWriteThrough();
    int r0, s0;
    cfgCopyBack = 1'b0;
    r0 = nBurstRd; s0 = nSingleWr;
    doReq(1, 32'h0000_0808, 32'hA002_0808, 32'hCAFE_F00D, 4'b1100);
    check(nSingleWr == s0 + 1 && nBurstRd == r0, "R7", "one single write on hit", 32'(nSingleWr - s0), 1);
    check(lastSgAddr == 32'hA002_0808 && lastSgBe == 4'b1100, "R7", "write address and enables",
          lastSgAddr, 32'hA002_0808);
    doReq(0, 32'h0000_0808, 32'hA002_0808, 0, 0);
    check(rd == truthWord(32'hA002_0808) && lat == 2, "R7", "line updated", rd, truthWord(32'hA002_0808));
    check(memWord(32'hA002_0808) == truthWord(32'hA002_0808), "R11", "memory bytes merged",
          memWord(32'hA002_0808), truthWord(32'hA002_0808));
    r0 = nBurstRd; s0 = nSingleWr;
    doReq(1, 32'h0000_0C10, 32'hB000_0C10, 32'h0BAD_F00D, 4'b1111);
    check(nSingleWr == s0 + 1 && nBurstRd == r0, "R8", "store miss no allocate", 32'(nBurstRd - r0), 0);
    doReq(0, 32'h0000_0C10, 32'hB000_0C10, 0, 0);
    check(nBurstRd == r0 + 1 && lastRdAddr == 32'hB000_0C00, "R8", "later load misses",
          lastRdAddr, 32'hB000_0C00);
    check(rd == 32'h0BAD_F00D, "R8", "load sees written word", rd, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testMissThenHit();
    testIndexTag();
    testCopyBackWrite();
    testLruWriteBack();
    testWriteThrough();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule